// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Bank

This block drives a set of pulse-width-modulated outputs, one for each channel, from a 32-bit register port. The port is a plain single-cycle bus with address, write data, write strobe, read strobe and read data. Each channel has three settings, all counted in clock cycles: the length of one period, the number of high cycles at the start of each period (the duty), and a start delay (the offset). Software writes these settings into shadow copies. They reach the waveform generators only when software sets the load bit in the configuration register. One load commits every channel at the same edge and restarts all of their counters together, so channels with harmonic periods stay phase-aligned.

A soft reset bit in the configuration register is set at power-up. While it is set, the committed settings are held at zero and every output is low. Clearing it releases the core. A single write can clear the reset bit and issue a load together. Read-only registers give a fixed magic word, a version with major number 2, an identification value and the number of channels. A scratch register can be written and read freely.

Top module: `pwm_bank`

## Requirements
- R1: After power-up the configuration register reads 0x1 (bit 0, soft reset, is set). While that bit is 1, every output is low and the committed period, duty and offset of every channel are forced to 0, so clearing the bit without a load leaves all outputs low.
- R2: Byte address 0x0C reads 0x601A3471. Address 0x00 reads the version, with 2 in bits 31:16. Address 0x04 reads the ID parameter (default 5). Address 0x14 reads the channel count (default 4).
- R3: The scratch register at byte address 0x08 reads back the last value written to it.
- R4: Channel n has its period at 0x40+4n, its duty at 0x80+4n and its offset at 0xC0+4n. Each reads back the value last written. A write changes no output until the next load.
- R5: A configuration write (address 0x10) with bit 1 set and bit 0 clear commits the shadow settings of every channel at the same edge. Bit 1 always reads back as 0.
- R6: The cycle after a load with offset 0, a channel's output is high for duty cycles and then low for period minus duty cycles. This pattern repeats.
- R7: A duty equal to or larger than the period holds the output high for all cycles. A duty of 0 holds it low.
- R8: A channel whose committed period is 0 drives its output low.
- R9: After a load, a channel holds its output low for offset cycles, and its first period starts after that.
- R10: A load restarts the counters of all channels at the same edge, even in the middle of a period. The cycle after the load, a channel with nonzero duty and offset 0 is high.
- R11: A single configuration write of 0x2 while soft reset is set releases the reset and commits the shadow settings.
- R12: Read data appears on the cycle after the read strobe. Unmapped addresses, including channel slots at or above the channel count, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pwm_o | output | NCH (4) | One waveform output per channel |

## Verification
Assertions check several properties on every cycle. Outputs stay low while soft reset is set. A running channel's counter stays below its committed period. Committed settings do not change between loads. Each load returns the counter to zero, and the magic word appears on every read of its address. The bench scenarios cover the waveform shapes: high and low run lengths, the offset delay, saturated and zero duty, and a period truncated when two channels restart together. They also show that a write to a shadow register leaves the running waveform unchanged, and that a single write can release the reset and load at once.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   localparam int unsigned CNT_W = 32;

   localparam logic [5:0] A_VER   = 6'h00;
   localparam logic [5:0] A_ID    = 6'h04;
   localparam logic [5:0] A_SCR   = 6'h08;
   localparam logic [5:0] A_MAGIC = 6'h0C;
   localparam logic [5:0] A_CFG   = 6'h10;
   localparam logic [5:0] A_NCH   = 6'h14;

   localparam logic [1:0] PG_GLOB = 2'b00;
   localparam logic [1:0] PG_PER  = 2'b01;
   localparam logic [1:0] PG_DUTY = 2'b10;
   localparam logic [1:0] PG_OFF  = 2'b11;

   localparam logic [31:0] MAGIC_WORD = 32'h601A3471;
   localparam logic [15:0] VER_MAJOR  = 16'd2;

   typedef struct packed {
      logic [CNT_W-1:0] per;
      logic [CNT_W-1:0] duty;
      logic [CNT_W-1:0] off;
   } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH       = 4,
   parameter int unsigned AW        = 8,
   parameter logic [31:0] ID_VAL    = 32'd5,
   parameter int unsigned VER_MINOR = 1,
   parameter int unsigned VER_PATCH = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic          rd_i,
   input  logic [AW-1:0] addr_i,
   input  logic [31:0]   wdata_i,
   output logic [31:0]   rdata_o,
   output logic          core_rst_o,
   output logic          hold_o,
   output logic          load_o,
   output chan_cfg_t     shd_o [NCH]
);
   localparam logic [31:0] VER_WORD = {VER_MAJOR, 8'(VER_MINOR), 8'(VER_PATCH)};
   localparam logic [31:0] NCH_WORD = 32'(NCH);

   logic [31:0]      scr_q;
   logic             rst_q;
   logic [CNT_W-1:0] per_q  [NCH];
   logic [CNT_W-1:0] duty_q [NCH];
   logic [CNT_W-1:0] off_q  [NCH];

   logic       in_pg;
   logic [1:0] pg;
   logic [3:0] idx;
   logic       cfg_wr;
   logic [31:0] rd_mux;

   assign in_pg  = ((addr_i >> 8) == '0) && (addr_i[1:0] == 2'b00);
   assign pg     = addr_i[7:6];
   assign idx    = addr_i[5:2];
   assign cfg_wr = wr_i && in_pg && (pg == PG_GLOB) && (addr_i[5:0] == A_CFG);

   assign hold_o     = cfg_wr ? wdata_i[0] : rst_q;
   assign load_o     = cfg_wr && wdata_i[1] && !wdata_i[0];
   assign core_rst_o = rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scr_q <= '0;
         rst_q <= 1'b1;
      end else if (wr_i && in_pg && pg == PG_GLOB) begin
         if (addr_i[5:0] == A_SCR) scr_q <= wdata_i;
         if (addr_i[5:0] == A_CFG) rst_q <= wdata_i[0];
      end
   end

   for (genvar n = 0; n < NCH; n++) begin : g_shd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_q[n]  <= '0;
            duty_q[n] <= '0;
            off_q[n]  <= '0;
         end else if (wr_i && in_pg && idx == 4'(n)) begin
            if (pg == PG_PER)  per_q[n]  <= wdata_i;
            if (pg == PG_DUTY) duty_q[n] <= wdata_i;
            if (pg == PG_OFF)  off_q[n]  <= wdata_i;
         end
      end
      assign shd_o[n] = '{per: per_q[n], duty: duty_q[n], off: off_q[n]};
   end

   always_comb begin
      rd_mux = '0;
      if (in_pg) begin
         if (pg == PG_GLOB) begin
            case (addr_i[5:0])
               A_VER:   rd_mux = VER_WORD;
               A_ID:    rd_mux = ID_VAL;
               A_SCR:   rd_mux = scr_q;
               A_MAGIC: rd_mux = MAGIC_WORD;
               A_CFG:   rd_mux = {31'd0, rst_q};
               A_NCH:   rd_mux = NCH_WORD;
               default: rd_mux = '0;
            endcase
         end else begin
            for (int n = 0; n < NCH; n++) begin
               if (idx == 4'(n)) begin
                  case (pg)
                     PG_PER:  rd_mux = per_q[n];
                     PG_DUTY: rd_mux = duty_q[n];
                     default: rd_mux = off_q[n];
                  endcase
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= rd_mux;
   end

   // R2: the magic word is returned on every read of its address
   p_magic_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && (addr_i == AW'(A_MAGIC))) |=> (rdata_o == MAGIC_WORD));

   // R5: the load bit never reads back as set
   p_load_rd0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && (addr_i == AW'(A_CFG))) |=> !rdata_o[1]);
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
   import pwm_bank_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hold_i,
   input  logic      load_i,
   input  chan_cfg_t shd_i,
   output logic      pwm_o
);
   chan_cfg_t        act_q;
   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (hold_i) begin
         act_q <= '0;
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_i) begin
         act_q <= shd_i;
         run_q <= (shd_i.off == '0);
         cnt_q <= '0;
      end else if (act_q.per != '0) begin
         if (!run_q) begin
            if (cnt_q >= act_q.off - 1'b1) begin
               run_q <= 1'b1;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (cnt_q >= act_q.per - 1'b1) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pwm_o = run_q && (act_q.per != '0) && (cnt_q < act_q.duty);

   // R6: the running counter never reaches the committed period
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && act_q.per != '0) |-> (cnt_q < act_q.per));

   // R10: every load sends the counter back to zero
   p_load_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !hold_i) |=> (cnt_q == '0));

   // R4: committed settings only move on a load or a reset
   p_hold_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !hold_i) |=> $stable(act_q));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH       = 4,
   parameter int unsigned AW        = 8,
   parameter logic [31:0] ID_VAL    = 32'd5,
   parameter int unsigned VER_MINOR = 1,
   parameter int unsigned VER_PATCH = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_wr,
   input  logic           bus_rd,
   input  logic [AW-1:0]  bus_addr,
   input  logic [31:0]    bus_wdata,
   output logic [31:0]    bus_rdata,
   output logic [NCH-1:0] pwm_o
);
   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("pwm_bank: NCH must lie in 1..16");
   end
   if (AW < 8) begin : g_bad_aw
      $error("pwm_bank: AW must be at least 8");
   end
   if (VER_MINOR > 255 || VER_PATCH > 255) begin : g_bad_ver
      $error("pwm_bank: version fields are 8 bits wide");
   end

   logic      core_rst;
   logic      hold;
   logic      load;
   chan_cfg_t shd [NCH];

   pwm_bank_regs #(
      .NCH(NCH), .AW(AW), .ID_VAL(ID_VAL),
      .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr),
      .rd_i      (bus_rd),
      .addr_i    (bus_addr),
      .wdata_i   (bus_wdata),
      .rdata_o   (bus_rdata),
      .core_rst_o(core_rst),
      .hold_o    (hold),
      .load_o    (load),
      .shd_o     (shd)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      pwm_bank_chan u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .hold_i(hold),
         .load_i(load),
         .shd_i (shd[n]),
         .pwm_o (pwm_o[n])
      );
   end

   // R1: soft reset silences every output
   p_rst_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> (pwm_o == '0));
endmodule

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_wr = 1'b0;
   logic           bus_rd = 1'b0;
   logic [7:0]     bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [NCH-1:0] pwm_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_o(pwm_o)
   );

   // period, duty, offset for channel 0
   localparam int VEC [6][3] = '{
      '{5, 2, 0},    // R6 plain waveform
      '{4, 4, 0},    // R7 duty equal to period
      '{3, 9, 2},    // R7 duty above period, R9 offset
      '{6, 0, 1},    // R7 zero duty
      '{0, 3, 0},    // R8 zero period
      '{7, 3, 3}     // R9 offset
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic bit model(input int per, input int duty, input int off, input int t);
      if (per == 0 || t < off) return 1'b0;
      return ((t - off) % per) < duty;
   endfunction

   task automatic prog(input int ch, input int per, input int duty, input int off);
      wr(8'(8'h40 + 4 * ch), 32'(per));
      wr(8'(8'h80 + 4 * ch), 32'(duty));
      wr(8'(8'hC0 + 4 * ch), 32'(off));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int mism;
      int highs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h10, d);   chk(d == 32'h1, "R1 cfg after reset", d, 32'h1);
      chk(pwm_o == '0, "R1 outputs after reset", 32'(pwm_o), 0);

      // R2 identification
      rd(8'h0C, d);   chk(d == 32'h601A3471, "R2 magic", d, 32'h601A3471);
      rd(8'h00, d);   chk(d[31:16] == 16'd2, "R2 version major", 32'(d[31:16]), 2);
      rd(8'h04, d);   chk(d == 32'd5, "R2 id", d, 5);
      rd(8'h14, d);   chk(d == 32'd4, "R2 channel count", d, 4);

      // R3 scratch
      wr(8'h08, 32'hA5A5_1234);
      rd(8'h08, d);   chk(d == 32'hA5A5_1234, "R3 scratch", d, 32'hA5A5_1234);

      // R12 unmapped reads
      rd(8'h20, d);   chk(d == 0, "R12 unmapped global", d, 0);
      rd(8'h54, d);   chk(d == 0, "R12 channel slot above count", d, 0);

      wr(8'h10, 32'h0);

      // vector table on channel 0
      for (int i = 0; i < 6; i++) begin
         prog(0, VEC[i][0], VEC[i][1], VEC[i][2]);
         wr(8'h10, 32'h2);
         mism = 0;
         for (int t = 0; t < 24; t++) begin
            if (pwm_o[0] != model(VEC[i][0], VEC[i][1], VEC[i][2], t)) mism++;
            @(negedge clk);
         end
         chk(mism == 0, $sformatf("R6/R7/R8/R9 vector %0d mismatches", i), 32'(mism), 0);
      end

      // R4 readback of last vector
      rd(8'h40, d);   chk(d == 7, "R4 period readback", d, 7);
      rd(8'h80, d);   chk(d == 3, "R4 duty readback", d, 3);
      rd(8'hC0, d);   chk(d == 3, "R4 offset readback", d, 3);
      // R5 load bit reads 0
      rd(8'h10, d);   chk(d == 0, "R5 cfg after load", d, 0);

      // R4 shadow write has no effect until load
      prog(0, 4, 2, 0);
      wr(8'h10, 32'h2);
      wr(8'h80, 32'h0);
      highs = 0;
      for (int t = 0; t < 8; t++) begin
         if (pwm_o[0]) highs++;
         @(negedge clk);
      end
      chk(highs == 4, "R4 shadow duty not applied", 32'(highs), 4);
      rd(8'h80, d);   chk(d == 0, "R4 shadow duty readback", d, 0);

      // R5 one load commits all channels, R8 channel 3 stays low
      prog(0, 4, 2, 0);
      prog(1, 3, 1, 0);
      prog(2, 2, 2, 1);
      wr(8'h10, 32'h2);
      mism = 0;
      for (int t = 0; t < 12; t++) begin
         if (pwm_o[0] != model(4, 2, 0, t)) mism++;
         if (pwm_o[1] != model(3, 1, 0, t)) mism++;
         if (pwm_o[2] != model(2, 2, 1, t)) mism++;
         if (pwm_o[3] != 1'b0) mism++;
         @(negedge clk);
      end
      chk(mism == 0, "R5 all channels from one load", 32'(mism), 0);

      // R10 reload mid-period restarts both channels together
      prog(0, 10, 5, 0);
      prog(1, 5, 2, 0);
      wr(8'h10, 32'h2);
      repeat (7) @(negedge clk);
      wr(8'h10, 32'h2);
      chk(pwm_o[1:0] == 2'b11, "R10 both high after reload", 32'(pwm_o[1:0]), 3);
      mism = 0;
      for (int t = 0; t < 20; t++) begin
         if (pwm_o[0] != model(10, 5, 0, t)) mism++;
         if (pwm_o[1] != model(5, 2, 0, t)) mism++;
         @(negedge clk);
      end
      chk(mism == 0, "R10 aligned waveforms after reload", 32'(mism), 0);

      // R1 soft reset silences and clears
      wr(8'h10, 32'h1);
      mism = 0;
      for (int t = 0; t < 5; t++) begin
         if (pwm_o != '0) mism++;
         @(negedge clk);
      end
      chk(mism == 0, "R1 outputs low in soft reset", 32'(mism), 0);
      rd(8'h10, d);   chk(d == 1, "R1 cfg reads reset", d, 1);
      wr(8'h10, 32'h0);
      mism = 0;
      for (int t = 0; t < 5; t++) begin
         if (pwm_o != '0) mism++;
         @(negedge clk);
      end
      chk(mism == 0, "R1 release without load stays low", 32'(mism), 0);

      // R11 release and load in one write
      wr(8'h10, 32'h1);
      prog(0, 4, 4, 0);
      wr(8'h10, 32'h2);
      mism = 0;
      for (int t = 0; t < 8; t++) begin
         if (pwm_o[0] != 1'b1) mism++;
         @(negedge clk);
      end
      chk(mism == 0, "R11 release plus load", 32'(mism), 0);
      rd(8'h10, d);   chk(d == 0, "R11 cfg after release", d, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule